// File: doc/BRIEF.md
# Two-Channel High/Low Count Pulse Generator

This block drives two independent pulse-width modulated outputs. For each channel it keeps two counts: how many prescaled ticks the output stays high, and how many it stays low. One period is the sum of the two counts. The period starts in the high phase. Each channel has its own prescaler. The prescaler counts strobes on that channel's source-tick input and emits one prescaled tick after every (divide field + 1) strobes. The source-tick input is a one-cycle strobe in the bus clock domain and represents that channel's input clock.

Software programs the block through a small 32-bit register port with three words: one duty word per channel and one shared control word. A channel runs only when both its prescaler enable and its output enable are set. Otherwise its output is held low and its counters are cleared. New duty values take effect at the next period boundary, so a running period is never cut short and never mixes old and new counts.

Top module: `pwm2_top`

## Requirements
- R1: Word index `bus_addr[3:2]` selects the register: 0 is the channel A duty word, 1 is the channel B duty word, 2 is the control word, and 3 reads as zero. Each register reads back the last value written to it, in the same cycle the address is presented. In the control word, only bits 0, 1 and 8 to 23 are stored, and all other bits read as zero. All registers reset to zero.
- R2: In a duty word, bits 31:16 give the high count and bits 15:0 give the low count. A running channel drives its output high for the high count of prescaled ticks, then low for the low count, and then repeats.
- R3: The prescaler divide field is control bits 14:8 for channel A and bits 22:16 for channel B. A field value of d gives one prescaled tick for every d+1 source ticks, so ratios from 1 to 128 are possible.
- R4: Channel A runs only when control bit 15 (prescaler enable) and bit 0 (output enable) are both set. Channel B runs only when bit 23 and bit 1 are both set. When a channel is not running, its output is low.
- R5: A high count of zero keeps the output low for the whole period. A low count of zero with a nonzero high count keeps the output high.
- R6: A duty write made while the channel is running takes effect at the next period boundary.
- R7: When a channel stops running, its output goes low at once and its prescaler and phase counter are cleared. When it runs again, it starts a fresh period in the high phase, using the current duty word.
- R8: The two channels run independently, each with its own counts and divide ratio.
- R9: The counters of a running channel advance only on cycles where its source-tick input is high. With no ticks, the output holds its level.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus and logic clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_wr | input | 1 | Write strobe for the register port |
| bus_addr | input | 4 | Byte address; bits 3:2 select the word |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for the addressed word (combinational) |
| src_tick_a | input | 1 | Source clock strobe for channel A |
| src_tick_b | input | 1 | Source clock strobe for channel B |
| pwm_a | output | 1 | Channel A output, active high |
| pwm_b | output | 1 | Channel B output, active high |

## Verification
The bench uses the default parameters: 16-bit phase counts and a 7-bit divide field. With these values the divide ratios used (1, 2, 3, 4 and 6) and short counts of zero to five ticks can be checked tick by tick against an arithmetic model. The model is the count position (cycle / ratio) modulo (high + low). Short periods also allow a mid-period duty change, a stop while in the low phase, and a tick-starved run, each to be followed past one or two boundaries within a few dozen cycles.

// File: rtl/pwm2_pkg.sv
package pwm2_pkg;
    localparam int DATA_W = 32;
    localparam int CNT_W  = 16;
    localparam int DIV_W  = 7;
    localparam int NUM_CH = 2;
    localparam int ADDR_W = 4;
    localparam int PER_W  = CNT_W + 1;
    localparam logic [DATA_W-1:0] CTRL_MASK = 32'h00FF_FF03;

    typedef enum logic [1:0] {
        WORD_DUTY_A = 2'd0,
        WORD_DUTY_B = 2'd1,
        WORD_CTRL   = 2'd2,
        WORD_NONE   = 2'd3
    } word_sel_t;

    typedef struct packed {
        logic [CNT_W-1:0] hi;
        logic [CNT_W-1:0] lo;
    } duty_t;

    typedef struct packed {
        logic             pre_en;
        logic [DIV_W-1:0] div;
        logic             out_en;
    } ch_cfg_t;

    // Control word layout: output enables at bit ch, divide field and
    // prescaler enable in byte (1 + ch).
    function automatic ch_cfg_t ctrl_field(input logic [DATA_W-1:0] ctrl, input int ch);
        ch_cfg_t c;
        c.out_en = ctrl[ch];
        c.div    = ctrl[8 + 8*ch +: DIV_W];
        c.pre_en = ctrl[15 + 8*ch];
        return c;
    endfunction
endpackage

// File: rtl/pwm2_regs.sv
module pwm2_regs
    import pwm2_pkg::*;
(
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  bus_wr,
    input  logic [ADDR_W-1:0]     bus_addr,
    input  logic [DATA_W-1:0]     bus_wdata,
    output logic [DATA_W-1:0]     bus_rdata,
    output duty_t [NUM_CH-1:0]    duty_o,
    output logic [DATA_W-1:0]     ctrl_o
);
    word_sel_t sel;
    assign sel = word_sel_t'(bus_addr[3:2]);

    always_ff @(posedge clk) begin
        if (rst) begin
            duty_o <= '0;
            ctrl_o <= '0;
        end else if (bus_wr) begin
            case (sel)
                WORD_DUTY_A: duty_o[0] <= duty_t'(bus_wdata);
                WORD_DUTY_B: duty_o[1] <= duty_t'(bus_wdata);
                WORD_CTRL:   ctrl_o    <= bus_wdata & CTRL_MASK;
                default: ;
            endcase
        end
    end

    always_comb begin
        case (sel)
            WORD_DUTY_A: bus_rdata = duty_o[0];
            WORD_DUTY_B: bus_rdata = duty_o[1];
            WORD_CTRL:   bus_rdata = ctrl_o;
            default:     bus_rdata = '0;
        endcase
    end
endmodule

// File: rtl/pwm2_prescaler.sv
module pwm2_prescaler
    import pwm2_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             run,
    input  logic             src_tick,
    input  logic [DIV_W-1:0] div,
    output logic             ptick
);
    logic [DIV_W-1:0] cnt_q;

    assign ptick = run && src_tick && (cnt_q == div);

    always_ff @(posedge clk) begin
        if (rst || !run)
            cnt_q <= '0;
        else if (src_tick)
            cnt_q <= (cnt_q == div) ? '0 : cnt_q + 1'b1;
    end
endmodule

// File: rtl/pwm2_phase.sv
module pwm2_phase
    import pwm2_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  logic  run,
    input  logic  ptick,
    input  duty_t duty,
    output logic  pwm_o
);
    duty_t            shadow_q;
    logic [PER_W-1:0] pos_q;
    logic [PER_W-1:0] total;
    logic             at_end;

    assign total  = {1'b0, shadow_q.hi} + {1'b0, shadow_q.lo};
    assign at_end = (total == '0) || (pos_q == total - 1'b1);
    assign pwm_o  = run && (pos_q < {1'b0, shadow_q.hi});

    always_ff @(posedge clk) begin
        if (rst || !run) begin
            pos_q    <= '0;
            shadow_q <= duty;
        end else if (ptick) begin
            if (at_end) begin
                pos_q    <= '0;
                shadow_q <= duty;
            end else begin
                pos_q <= pos_q + 1'b1;
            end
        end
    end
endmodule

// File: rtl/pwm2_channel.sv
module pwm2_channel
    import pwm2_pkg::*;
(
    input  logic    clk,
    input  logic    rst,
    input  logic    src_tick,
    input  ch_cfg_t cfg,
    input  duty_t   duty,
    output logic    pwm_o
);
    logic run;
    logic ptick;

    assign run = cfg.pre_en && cfg.out_en;

    pwm2_prescaler u_pre (
        .clk      (clk),
        .rst      (rst),
        .run      (run),
        .src_tick (src_tick),
        .div      (cfg.div),
        .ptick    (ptick)
    );

    pwm2_phase u_phase (
        .clk   (clk),
        .rst   (rst),
        .run   (run),
        .ptick (ptick),
        .duty  (duty),
        .pwm_o (pwm_o)
    );
endmodule

// File: rtl/pwm2_top.sv
module pwm2_top
    import pwm2_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    input  logic              src_tick_a,
    input  logic              src_tick_b,
    output logic              pwm_a,
    output logic              pwm_b
);
    duty_t [NUM_CH-1:0] duty_q;
    logic [DATA_W-1:0]  ctrl_q;
    logic [NUM_CH-1:0]  ticks;
    logic [NUM_CH-1:0]  outs;

    assign ticks = {src_tick_b, src_tick_a};
    assign pwm_a = outs[0];
    assign pwm_b = outs[1];

    pwm2_regs u_regs (
        .clk       (clk),
        .rst       (rst),
        .bus_wr    (bus_wr),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .duty_o    (duty_q),
        .ctrl_o    (ctrl_q)
    );

    for (genvar ch = 0; ch < NUM_CH; ch++) begin : g_ch
        pwm2_channel u_ch (
            .clk      (clk),
            .rst      (rst),
            .src_tick (ticks[ch]),
            .cfg      (ctrl_field(ctrl_q, ch)),
            .duty     (duty_q[ch]),
            .pwm_o    (outs[ch])
        );
    end
endmodule

// File: rtl/pwm2_checker.sv
module pwm2_checker
    import pwm2_pkg::*;
(
    input logic              clk,
    input logic              rst,
    input logic              bus_wr,
    input logic [ADDR_W-1:0] bus_addr,
    input logic [DATA_W-1:0] bus_rdata,
    input logic              src_tick_a,
    input logic              src_tick_b,
    input logic              pwm_a,
    input logic              pwm_b,
    input logic [DATA_W-1:0] ctrl,
    input logic [DATA_W-1:0] duty_a
);
    logic run_a, run_b;
    assign run_a = ctrl[15] && ctrl[0];
    assign run_b = ctrl[23] && ctrl[1];

    AST_CTRL_RSVD_ZERO: assert property (@(posedge clk) disable iff (rst) (bus_addr[3:2] == 2'd2) |-> ((bus_rdata & ~CTRL_MASK) == '0)); // R1
    AST_A_IDLE_LOW: assert property (@(posedge clk) disable iff (rst) !run_a |-> !pwm_a); // R4
    AST_B_IDLE_LOW: assert property (@(posedge clk) disable iff (rst) !run_b |-> !pwm_b); // R4
    AST_A_FRESH_HIGH: assert property (@(posedge clk) disable iff (rst) ($rose(run_a) && $stable(duty_a) && (duty_a[31:16] != '0)) |-> pwm_a); // R7
    AST_A_HOLD_NO_TICK: assert property (@(posedge clk) disable iff (rst) (run_a && !src_tick_a && !bus_wr) |=> $stable(pwm_a)); // R9
    AST_B_HOLD_NO_TICK: assert property (@(posedge clk) disable iff (rst) (run_b && !src_tick_b && !bus_wr) |=> $stable(pwm_b)); // R9
endmodule

bind pwm2_top pwm2_checker u_chk (
    .clk        (clk),
    .rst        (rst),
    .bus_wr     (bus_wr),
    .bus_addr   (bus_addr),
    .bus_rdata  (bus_rdata),
    .src_tick_a (src_tick_a),
    .src_tick_b (src_tick_b),
    .pwm_a      (pwm_a),
    .pwm_b      (pwm_b),
    .ctrl       (ctrl_q),
    .duty_a     (duty_q[0])
);

// File: tb/tb_pwm2_top.sv
module tb_pwm2_top;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        bus_wr = 1'b0;
    logic [3:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        src_tick_a = 1'b0;
    logic        src_tick_b = 1'b0;
    logic        pwm_a, pwm_b;
    int          n_chk = 0;
    int          n_err = 0;
    bit          done = 1'b0;

    always #5 clk = ~clk;

    pwm2_top dut (
        .clk(clk), .rst(rst), .bus_wr(bus_wr), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .src_tick_a(src_tick_a), .src_tick_b(src_tick_b),
        .pwm_a(pwm_a), .pwm_b(pwm_b)
    );

    typedef struct packed {
        logic        ch;
        logic [6:0]  div;
        logic [15:0] hi;
        logic [15:0] lo;
    } vec_t;

    localparam int NV = 7;
    localparam vec_t VECS [NV] = '{
        '{1'b0, 7'd0, 16'd3, 16'd2},
        '{1'b0, 7'd2, 16'd2, 16'd1},
        '{1'b1, 7'd0, 16'd1, 16'd4},
        '{1'b1, 7'd1, 16'd5, 16'd0},
        '{1'b0, 7'd0, 16'd0, 16'd4},
        '{1'b1, 7'd3, 16'd2, 16'd2},
        '{1'b0, 7'd5, 16'd1, 16'd1}
    };

    function automatic logic exp_out(int k, int div, int hi, int lo);
        int pos;
        if (hi + lo == 0) return 1'b0;
        pos = (k / (div + 1)) % (hi + lo);
        return pos < hi;
    endfunction

    function automatic logic [31:0] run_word(logic ch, logic [6:0] div);
        return ch ? ((32'd1 << 23) | ({25'd0, div} << 16) | 32'd2)
                  : ((32'd1 << 15) | ({25'd0, div} << 8)  | 32'd1);
    endfunction

    task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wr(logic [3:0] a, logic [31:0] d);
        @(negedge clk);
        bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic rd_chk(string req, logic [3:0] a, logic [31:0] exp);
        bus_addr = a;
        #1;
        chk(req, bus_rdata, exp);
    endtask

    task automatic wave(string req, logic ch, int div, int hi, int lo, int n);
        for (int k = 0; k < n; k++) begin
            chk(req, {31'd0, ch ? pwm_b : pwm_a}, {31'd0, exp_out(k, div, hi, lo)});
            @(negedge clk);
        end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_chk++; n_err++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("Result: errors=%0d of %0d checks", n_err, n_chk);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R1 reset values, R4 outputs low after reset
        rd_chk("R1 reset duty A", 4'h0, 32'h0);
        rd_chk("R1 reset duty B", 4'h4, 32'h0);
        rd_chk("R1 reset ctrl", 4'h8, 32'h0);
        chk("R4 reset outputs", {30'd0, pwm_b, pwm_a}, 32'h0);

        // R1 readback and masking
        wr(4'h0, 32'h1234_5678);
        wr(4'h4, 32'h9ABC_DEF0);
        wr(4'h8, 32'hFFFF_FFFF);
        wr(4'hC, 32'hFFFF_FFFF);
        rd_chk("R1 duty A readback", 4'h0, 32'h1234_5678);
        rd_chk("R1 duty B readback", 4'h4, 32'h9ABC_DEF0);
        rd_chk("R1 ctrl masked", 4'h8, 32'h00FF_FF03);
        rd_chk("R1 word 3 zero", 4'hC, 32'h0);
        wr(4'h8, 32'h0);

        // R2 R3 R5 table of waveforms, ticks every cycle
        src_tick_a = 1'b1; src_tick_b = 1'b1;
        for (int v = 0; v < NV; v++) begin
            wr(4'h8, 32'h0);
            wr(VECS[v].ch ? 4'h4 : 4'h0, {VECS[v].hi, VECS[v].lo});
            wr(4'h8, run_word(VECS[v].ch, VECS[v].div));
            wave("R2/R3/R5 table", VECS[v].ch, int'(VECS[v].div), int'(VECS[v].hi), int'(VECS[v].lo), 40);
        end

        // R4 prescaler enable alone, output enable alone
        wr(4'h8, 32'h0);
        wr(4'h0, {16'd3, 16'd1});
        wr(4'h8, 32'h0000_8000);
        repeat (6) begin chk("R4 pre_en only", {31'd0, pwm_a}, 32'd0); @(negedge clk); end
        wr(4'h8, 32'h0000_0001);
        repeat (6) begin chk("R4 out_en only", {31'd0, pwm_a}, 32'd0); @(negedge clk); end

        // R6 duty change mid-period lands on boundary
        wr(4'h8, 32'h0);
        wr(4'h0, {16'd3, 16'd3});
        @(negedge clk);
        bus_wr = 1'b1; bus_addr = 4'h8; bus_wdata = 32'h0000_8001;
        @(negedge clk);              // k = 0
        bus_addr = 4'h0; bus_wdata = {16'd1, 16'd1};
        @(negedge clk);              // k = 1, write landed at this edge
        bus_wr = 1'b0;
        @(negedge clk);              // k = 2
        chk("R6 old period k2", {31'd0, pwm_a}, 32'd1);
        @(negedge clk); chk("R6 old period k3", {31'd0, pwm_a}, 32'd0);
        @(negedge clk); chk("R6 old period k4", {31'd0, pwm_a}, 32'd0);
        @(negedge clk); chk("R6 old period k5", {31'd0, pwm_a}, 32'd0);
        @(negedge clk); chk("R6 new period k6", {31'd0, pwm_a}, 32'd1);
        @(negedge clk); chk("R6 new period k7", {31'd0, pwm_a}, 32'd0);
        @(negedge clk); chk("R6 new period k8", {31'd0, pwm_a}, 32'd1);

        // R7 stop in low phase then restart fresh
        wr(4'h8, 32'h0);
        wr(4'h0, {16'd2, 16'd5});
        wr(4'h8, 32'h0000_8001);
        repeat (4) @(negedge clk);
        chk("R7 in low phase", {31'd0, pwm_a}, 32'd0);
        wr(4'h8, 32'h0000_8000);
        chk("R7 stopped low", {31'd0, pwm_a}, 32'd0);
        wr(4'h8, 32'h0000_8001);
        wave("R7 fresh start", 1'b0, 0, 2, 5, 10);

        // R8 both channels at once, different settings
        wr(4'h8, 32'h0);
        wr(4'h0, {16'd1, 16'd1});
        wr(4'h4, {16'd2, 16'd2});
        wr(4'h8, 32'h0081_8003);
        for (int k = 0; k < 30; k++) begin
            chk("R8 channel A", {31'd0, pwm_a}, {31'd0, exp_out(k, 0, 1, 1)});
            chk("R8 channel B", {31'd0, pwm_b}, {31'd0, exp_out(k, 1, 2, 2)});
            @(negedge clk);
        end

        // R9 no source ticks, no progress
        wr(4'h8, 32'h0);
        src_tick_a = 1'b0;
        wr(4'h0, {16'd2, 16'd2});
        wr(4'h8, 32'h0000_8001);
        repeat (10) begin chk("R9 held without ticks", {31'd0, pwm_a}, 32'd1); @(negedge clk); end
        src_tick_a = 1'b1;
        wave("R9 resumes with ticks", 1'b0, 0, 2, 2, 8);

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end
endmodule